// File: doc/BRIEF.md
# Parallelism Hint Batch Checker

This block tells issue logic whether two element step indices may be treated as free of hazards between each other. A programmed parallelism hint splits the step space into batches: every step whose quotient `floor(step / hint)` is the same belongs to the same batch. The hint can be any value, including values that are not powers of two, so the block contains real dividers rather than shift-and-mask logic. Steps are taken before any index remapping and before predication. When the hint is zero, each element is treated as its own batch.

A mode input lets hardware use a smaller effective hint in place of the programmed one. The effective hint is only accepted when it divides the programmed hint exactly, because only then can its batches never span a true batch boundary. Otherwise the applied hint falls back to zero. Source and destination step pairs are judged by separate instances, one per pair. The results are presented through an optional one-cycle output register, which is enabled by default.

Top module: `hbc_top`

## Requirements
- R1: With a non-zero applied hint H, `batch_a_o` = floor(`step_a_i`/H), `batch_b_o` = floor(`step_b_i`/H), and `same_batch_o` is 1 exactly when the two quotients are equal.
- R2: With an applied hint of zero, each batch output equals its step index, and `same_batch_o` is 1 only when the two steps are equal.
- R3: Hints that are not powers of two (for example 3, 5, 6, 7) give exact floor-division batches.
- R4: A hint larger than both steps puts both steps in batch 0 and reports them in the same batch.
- R5: With `mode_i` = 0, the applied hint is `hint_i`, and `eff_hint_i` has no effect on any output.
- R6: With `mode_i` = 1, if `hint_i` is non-zero, `eff_hint_i` is non-zero and `hint_i` mod `eff_hint_i` = 0, then the applied hint is `eff_hint_i`.
- R7: With `mode_i` = 1, the applied hint is zero when `eff_hint_i` is zero, when `hint_i` is zero, or when `eff_hint_i` does not divide `hint_i` exactly.
- R8: With the output register enabled, all outputs appear one clock after their inputs. A synchronous active-high reset clears every output to zero.
- R9: `applied_hint_o` reports the hint actually used for the batches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hint_i | input | HINT_W | Programmed parallelism hint |
| eff_hint_i | input | HINT_W | Proposed smaller effective hint |
| mode_i | input | 1 | 0: use programmed hint, 1: use effective hint if it divides |
| step_a_i | input | STEP_W | First element step index |
| step_b_i | input | STEP_W | Second element step index |
| same_batch_o | output | 1 | Both steps lie in one batch |
| batch_a_o | output | STEP_W | Batch number of step A |
| batch_b_o | output | STEP_W | Batch number of step B |
| applied_hint_o | output | HINT_W | Hint used for the batch computation |

## Verification
On every cycle, the assertions check four things. The applied hint always divides the programmed hint and never exceeds it. Equal steps always report the same batch. A zero applied hint never joins two distinct steps. The same-batch flag never disagrees with the two batch numbers. Only the bench's scenarios can show that the quotients are exact for specific non-power-of-two hints, that an effective hint which does not divide the programmed hint is rejected, that the effective hint is ignored in programmed mode, and that reset clears the outputs.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

    localparam int unsigned HBC_STEP_W = 7;
    localparam int unsigned HBC_HINT_W = 7;

    typedef enum logic {
        HM_PROG = 1'b0,
        HM_EFF  = 1'b1
    } hint_mode_e;

endpackage

// File: rtl/hbc_div.sv
module hbc_div #(
    parameter int unsigned NUM_W = 7,
    parameter int unsigned DEN_W = 7
) (
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic [NUM_W-1:0] quo_o,
    output logic [DEN_W-1:0] rem_o
);
    localparam int unsigned RW = DEN_W + 1;

    logic [RW-1:0] part;

    always_comb begin
        part  = '0;
        quo_o = '0;
        for (int i = NUM_W - 1; i >= 0; i--) begin
            part = {part[RW-2:0], num_i[i]};
            if (part >= {1'b0, den_i}) begin
                part     = part - {1'b0, den_i};
                quo_o[i] = 1'b1;
            end
        end
        rem_o = part[DEN_W-1:0];
    end
endmodule

// File: rtl/hbc_hint_sel.sv
module hbc_hint_sel
    import hbc_pkg::*;
#(
    parameter int unsigned HINT_W = 7
) (
    input  logic [HINT_W-1:0] hint_i,
    input  logic [HINT_W-1:0] eff_hint_i,
    input  hint_mode_e        mode_i,
    output logic [HINT_W-1:0] applied_o
);
    logic [HINT_W-1:0] quo_unused;
    logic [HINT_W-1:0] rem;
    logic              eff_ok;

    hbc_div #(.NUM_W(HINT_W), .DEN_W(HINT_W)) u_mod (
        .num_i (hint_i),
        .den_i (eff_hint_i),
        .quo_o (quo_unused),
        .rem_o (rem)
    );

    assign eff_ok = (hint_i != '0) && (eff_hint_i != '0) && (rem == '0);

    always_comb begin
        unique case (mode_i)
            HM_PROG: applied_o = hint_i;
            HM_EFF:  applied_o = eff_ok ? eff_hint_i : '0;
            default: applied_o = '0;
        endcase
    end
endmodule

// File: rtl/hbc_top.sv
module hbc_top
    import hbc_pkg::*;
#(
    parameter int unsigned STEP_W  = HBC_STEP_W,
    parameter int unsigned HINT_W  = HBC_HINT_W,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HINT_W-1:0] hint_i,
    input  logic [HINT_W-1:0] eff_hint_i,
    input  logic              mode_i,
    input  logic [STEP_W-1:0] step_a_i,
    input  logic [STEP_W-1:0] step_b_i,
    output logic              same_batch_o,
    output logic [STEP_W-1:0] batch_a_o,
    output logic [STEP_W-1:0] batch_b_o,
    output logic [HINT_W-1:0] applied_hint_o
);
    localparam int unsigned NSTEP = 2;

    typedef struct packed {
        logic              same;
        logic [STEP_W-1:0] batch_a;
        logic [STEP_W-1:0] batch_b;
        logic [HINT_W-1:0] applied;
    } batch_res_t;

    logic [HINT_W-1:0] applied;
    logic [STEP_W-1:0] steps [NSTEP];
    logic [STEP_W-1:0] quos  [NSTEP];
    logic [STEP_W-1:0] batch [NSTEP];
    batch_res_t        res_c;
    batch_res_t        res_q;

    hbc_hint_sel #(.HINT_W(HINT_W)) u_sel (
        .hint_i     (hint_i),
        .eff_hint_i (eff_hint_i),
        .mode_i     (hint_mode_e'(mode_i)),
        .applied_o  (applied)
    );

    assign steps[0] = step_a_i;
    assign steps[1] = step_b_i;

    for (genvar g = 0; g < NSTEP; g++) begin : g_step
        logic [HINT_W-1:0] rem_unused;
        hbc_div #(.NUM_W(STEP_W), .DEN_W(HINT_W)) u_div (
            .num_i (steps[g]),
            .den_i (applied),
            .quo_o (quos[g]),
            .rem_o (rem_unused)
        );
        assign batch[g] = (applied == '0) ? steps[g] : quos[g];
    end

    always_comb begin
        res_c.batch_a = batch[0];
        res_c.batch_b = batch[1];
        res_c.same    = (batch[0] == batch[1]);
        res_c.applied = applied;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) res_q <= '0;
            else     res_q <= res_c;
        end

        p_eq_steps_r1: assert property (@(posedge clk) disable iff (rst)
            (step_a_i == step_b_i) |=> same_batch_o);

        p_zero_apart_r2: assert property (@(posedge clk) disable iff (rst)
            ((applied == '0) && (step_a_i != step_b_i)) |=> !same_batch_o);
    end else begin : g_comb
        assign res_q = res_c;
    end

    assign same_batch_o   = res_q.same;
    assign batch_a_o      = res_q.batch_a;
    assign batch_b_o      = res_q.batch_b;
    assign applied_hint_o = res_q.applied;

    p_applied_divides_r7: assert property (@(posedge clk) disable iff (rst)
        (applied != '0) |-> ((hint_i % applied) == '0));

    p_applied_le_hint_r6: assert property (@(posedge clk) disable iff (rst)
        applied <= hint_i);

    p_flag_matches_r1: assert property (@(posedge clk) disable iff (rst)
        same_batch_o |-> (batch_a_o == batch_b_o));
endmodule

// File: tb/hbc_top_tb.sv
module hbc_top_tb;
    localparam int unsigned SW = 7;
    localparam int unsigned HW = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [HW-1:0] hint = '0;
    logic [HW-1:0] eff = '0;
    logic          mode = 1'b0;
    logic [SW-1:0] sa = '0;
    logic [SW-1:0] sb = '0;
    logic          same;
    logic [SW-1:0] ba;
    logic [SW-1:0] bb;
    logic [HW-1:0] app;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    hbc_top u_dut (
        .clk (clk), .rst (rst), .hint_i (hint), .eff_hint_i (eff), .mode_i (mode),
        .step_a_i (sa), .step_b_i (sb), .same_batch_o (same),
        .batch_a_o (ba), .batch_b_o (bb), .applied_hint_o (app)
    );

    function automatic int model_hint(int h, int e, int m);
        if (m == 0) return h;
        if (h != 0 && e != 0 && (h % e) == 0) return e;
        return 0;
    endfunction

    function automatic int model_batch(int s, int h);
        return (h == 0) ? s : s / h;
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive at negedge, one register stage, sample at the following negedge
    task automatic apply(int h, int e, int m, int a, int b);
        @(negedge clk);
        hint = HW'(h); eff = HW'(e); mode = m[0]; sa = SW'(a); sb = SW'(b);
        @(negedge clk);
    endtask

    task automatic full_check(string req, int h, int e, int m, int a, int b);
        int ah, qa, qb;
        apply(h, e, m, a, b);
        ah = model_hint(h, e, m);
        qa = model_batch(a, ah);
        qb = model_batch(b, ah);
        chk({req, " applied"}, int'(app), ah);
        chk({req, " batch_a"}, int'(ba), qa);
        chk({req, " batch_b"}, int'(bb), qb);
        chk({req, " same"}, int'(same), int'(qa == qb));
    endtask

    task automatic t_reset();
        @(negedge clk);
        hint = 7'd5; sa = 7'd3; sb = 7'd4;
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R8 reset same", int'(same), 0);
        chk("R8 reset batch_a", int'(ba), 0);
        chk("R8 reset applied", int'(app), 0);
        rst = 1'b0;
    endtask

    task automatic t_latency();
        @(negedge clk);
        hint = 7'd4; eff = '0; mode = 1'b0; sa = 7'd9; sb = 7'd2;
        @(posedge clk); #1;
        @(negedge clk);
        chk("R8 one-cycle batch_a", int'(ba), 2);
        hint = 7'd3;
        #1;
        chk("R8 holds before edge", int'(ba), 2);
        @(negedge clk);
        chk("R8 updates after edge", int'(ba), 3);
    endtask

    task automatic t_pow2();
        full_check("R1 h4 same", 4, 0, 0, 4, 7);
        full_check("R1 h4 split", 4, 0, 0, 3, 4);
        full_check("R1 h8 far", 8, 0, 0, 15, 16);
    endtask

    task automatic t_nonpow2();
        full_check("R3 h3", 3, 0, 0, 5, 6);
        full_check("R3 h3 same", 3, 0, 0, 6, 8);
        full_check("R3 h5", 5, 0, 0, 9, 10);
        full_check("R3 h7", 7, 0, 0, 126, 119);
        for (int h = 1; h < 128; h += 9)
            for (int s = 0; s < 128; s += 13)
                full_check("R3 sweep", h, 0, 0, s, 127 - s);
    endtask

    task automatic t_zero();
        full_check("R2 distinct", 0, 0, 0, 10, 11);
        full_check("R2 equal", 0, 0, 0, 42, 42);
        chk("R2 equal flag", int'(same), 1);
    endtask

    task automatic t_large();
        full_check("R4 large", 127, 0, 0, 0, 126);
        chk("R4 same flag", int'(same), 1);
        chk("R4 batch zero", int'(ba), 0);
    endtask

    task automatic t_mode_prog();
        apply(6, 0, 0, 5, 7);
        chk("R5 eff0 batch_b", int'(bb), 1);
        chk("R5 eff0 applied", int'(app), 6);
        apply(6, 4, 0, 5, 7);
        chk("R5 eff4 batch_b", int'(bb), 1);
        chk("R5 eff4 applied", int'(app), 6);
        chk("R5 eff4 same", int'(same), 0);
    endtask

    task automatic t_eff_ok();
        full_check("R6 12/3", 12, 3, 1, 4, 5);
        chk("R9 applied 3", int'(app), 3);
        full_check("R6 12/4 split", 12, 4, 1, 3, 4);
        full_check("R6 10/10", 10, 10, 1, 2, 9);
    endtask

    task automatic t_eff_bad();
        full_check("R7 nondiv", 12, 5, 1, 2, 3);
        chk("R7 nondiv applied", int'(app), 0);
        full_check("R7 eff zero", 12, 0, 1, 2, 3);
        full_check("R7 hint zero", 0, 3, 1, 1, 2);
        chk("R7 hint zero same", int'(same), 0);
        full_check("R7 eff>hint", 4, 8, 1, 1, 2);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        t_reset();
        t_latency();
        t_pow2();
        t_nonpow2();
        t_zero();
        t_large();
        t_mode_prog();
        t_eff_ok();
        t_eff_bad();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule